// File: doc/BRIEF.md
# Indirect Operand Access Sequencer

This block runs the memory accesses that fetch or store the memory operand of a 16-bit two-operand instruction. A start strobe brings in a 3-bit addressing-mode field, which is also the index of the data counter in use, together with a read/write select, the write data and the current values of all eight counters. The block then talks to a synchronous request/acknowledge memory port. When the operation ends, it raises a one-cycle done strobe. In that same cycle it presents the assembled read operand and, where the mode calls for it, the new value for one counter.

Each counter index follows its own rule. Index 0 selects direct mode: the operand address is the word that follows the instruction, read through the program counter (index 7). Indices 1 to 3 point at memory and are left unchanged. Indices 4 and 5 step up after each access. Index 6 is a stack that grows upward: it steps down before a read and up after a write. Index 7 is immediate mode, an indirect access through the program counter, which then steps past the operand.

A one-shot prefix flag splits a single word access into two byte accesses, low byte first. The flag is set by a strobe and is used up by the next start.

Top module: `operand_seq`

## Requirements
- R1: After reset, mem_req_o, done_o and upd_en_o are all low.
- R2: Mode 0 (direct) first reads the word at the address held in counter 7. That word's value becomes the operand address for exactly one access. At done, counter 7 is updated to its old value + 1 (upd_idx_o = 7). The prefix flag has no effect in this mode and is still cleared.
- R3: Modes 1 to 3 access the address held in counter[mode]. upd_en_o stays low at done.
- R4: Modes 4 and 5 access counter[mode]. At done, that counter is updated to its old value + number of accesses.
- R5: Mode 6 read: the first access is at counter 6 − 1, and the update is counter 6 − number of accesses. Mode 6 write: the first access is at counter 6, and the update is counter 6 + number of accesses.
- R6: Mode 7 (immediate) accesses counter 7. At done, counter 7 is updated to its old value + number of accesses.
- R7: With the prefix flag set and mode 1 to 7, two accesses are made. Address stepping: the second address equals the first for modes 1 to 3, is the first + 1 for modes 4, 5 and 7 and for a mode-6 write, and is the first − 1 for a mode-6 read. A read returns {second[7:0], first[7:0]}. A write sends {8'h00, wdata[7:0]} first and {8'h00, wdata[15:8]} second.
- R8: A single-access read returns the memory word unchanged on rdata_o, with no masking.
- R9: dbl_set_i sets the prefix flag. Any accepted start clears it, so only the next operation is split.
- R10: done_o is a one-cycle pulse. It comes one cycle after the last acknowledge, and rdata_o and upd_* are valid in that cycle.
- R11: start_i is ignored while an operation is in progress.
- R12: While mem_req_o is high and not yet acknowledged, mem_addr_o, mem_we_o and mem_wdata_o hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbl_set_i | input | 1 | Sets the one-shot byte-split flag |
| start_i | input | 1 | Starts an operand access |
| mode_i | input | 3 | Addressing mode / counter index |
| wr_i | input | 1 | 1 = write operand, 0 = read |
| wdata_i | input | 16 | Operand to write |
| ctrs_i | input | 128 | Counter values, counter k at bits [16k+15:16k] |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge, completes the current access |
| mem_rdata_i | input | 16 | Memory read data, valid with acknowledge |
| done_o | output | 1 | Operation complete, one cycle |
| rdata_o | output | 16 | Assembled read operand |
| upd_en_o | output | 1 | Counter update valid |
| upd_idx_o | output | 3 | Index of counter to update |
| upd_val_o | output | 16 | New counter value |

## Verification
- Start timing: a start sampled at one edge puts the first request on the port after that same edge. Each acknowledge moves the sequence on at the next edge.
- Done timing: done_o, rdata_o and the counter update appear exactly one cycle after the edge that takes the last acknowledge.
- How the bench meets this: it drives inputs and acknowledges on the falling edge and tags every acknowledge with the current cycle number. When done_o shows up, it checks that the cycle count is exactly one greater than the last tag.
- Request stability: with acknowledge wait states inserted, the bench compares the request fields on each waiting cycle against the previous cycle to confirm they hold.

// File: rtl/opseq_pkg.sv
package opseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PTR,
    ST_ACC1,
    ST_ACC2,
    ST_DONE
  } opseq_st_e;
endpackage

// File: rtl/opseq_flag.sv
module opseq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic take_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (take_i) flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
  end

  AST_FLAG_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !flag_o); // R9
endmodule

// File: rtl/opseq_ctr_rule.sv
module opseq_ctr_rule #(
  parameter int DW     = 16,
  parameter int MODE_W = 3
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic              wr_i,
  input  logic              dbl_i,
  input  logic [DW-1:0]     base_i,
  input  logic [DW-1:0]     cur_i,
  output logic [DW-1:0]     first_addr_o,
  output logic [DW-1:0]     next_addr_o,
  output logic              upd_en_o,
  output logic [DW-1:0]     upd_val_o
);
  localparam int NCTR  = 1 << MODE_W;
  localparam int IMM   = NCTR - 1;
  localparam int STK   = NCTR - 2;
  localparam int INC_B = NCTR - 3;
  localparam int INC_A = NCTR - 4;

  logic          autoinc, pop, push, direct;
  logic [DW-1:0] step;

  always_comb begin
    direct  = (mode_i == MODE_W'(0));
    autoinc = (mode_i == MODE_W'(INC_A)) || (mode_i == MODE_W'(INC_B)) ||
              (mode_i == MODE_W'(IMM));
    pop     = (mode_i == MODE_W'(STK)) && !wr_i;
    push    = (mode_i == MODE_W'(STK)) && wr_i;
    step    = dbl_i ? DW'(2) : DW'(1);

    first_addr_o = pop ? base_i - DW'(1) : base_i;

    if (autoinc || push) next_addr_o = cur_i + DW'(1);
    else if (pop)        next_addr_o = cur_i - DW'(1);
    else                 next_addr_o = cur_i;

    upd_en_o  = direct || autoinc || pop || push;
    upd_val_o = pop ? base_i - step : base_i + step;
  end
endmodule

// File: rtl/opseq_gather.sv
module opseq_gather #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lo_en_i,
  input  logic          hi_en_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] word_o
);
  localparam int BW = DW / 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_o <= '0;
    else if (lo_en_i) word_o <= rdata_i;
    else if (hi_en_i) word_o <= {rdata_i[BW-1:0], word_o[BW-1:0]};
  end
endmodule

// File: rtl/operand_seq.sv
module operand_seq
  import opseq_pkg::*;
#(
  parameter int DW     = 16,
  parameter int MODE_W = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    dbl_set_i,
  input  logic                    start_i,
  input  logic [MODE_W-1:0]       mode_i,
  input  logic                    wr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [(DW<<MODE_W)-1:0] ctrs_i,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [DW-1:0]           mem_addr_o,
  output logic [DW-1:0]           mem_wdata_o,
  input  logic                    mem_ack_i,
  input  logic [DW-1:0]           mem_rdata_i,
  output logic                    done_o,
  output logic [DW-1:0]           rdata_o,
  output logic                    upd_en_o,
  output logic [MODE_W-1:0]       upd_idx_o,
  output logic [DW-1:0]           upd_val_o
);
  localparam int NCTR = 1 << MODE_W;
  localparam int BW   = DW / 2;
  localparam logic [MODE_W-1:0] PC_IDX = MODE_W'(NCTR - 1);

  opseq_st_e         st_q;
  logic [MODE_W-1:0] mode_q;
  logic              wr_q, dbl_q;
  logic [DW-1:0]     wdata_q, base_q, addr_q;
  logic              flag, accept, ack_acc1, ack_acc2;
  logic [MODE_W-1:0] sel;
  logic [DW-1:0]     base_sel, first_addr, next_addr;
  logic              upd_en;

  assign accept   = start_i && (st_q == ST_IDLE);
  assign sel      = (mode_i == MODE_W'(0)) ? PC_IDX : mode_i;
  assign base_sel = ctrs_i[sel*DW +: DW];
  assign ack_acc1 = (st_q == ST_ACC1) && mem_ack_i;
  assign ack_acc2 = (st_q == ST_ACC2) && mem_ack_i;

  opseq_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (dbl_set_i),
    .take_i (accept),
    .flag_o (flag)
  );

  opseq_ctr_rule #(.DW(DW), .MODE_W(MODE_W)) u_rule (
    .mode_i       (st_q == ST_IDLE ? mode_i : mode_q),
    .wr_i         (st_q == ST_IDLE ? wr_i : wr_q),
    .dbl_i        (dbl_q),
    .base_i       (st_q == ST_IDLE ? base_sel : base_q),
    .cur_i        (addr_q),
    .first_addr_o (first_addr),
    .next_addr_o  (next_addr),
    .upd_en_o     (upd_en),
    .upd_val_o    (upd_val_o)
  );

  opseq_gather #(.DW(DW)) u_gather (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lo_en_i (ack_acc1),
    .hi_en_i (ack_acc2),
    .rdata_i (mem_rdata_i),
    .word_o  (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      mode_q  <= '0;
      wr_q    <= 1'b0;
      dbl_q   <= 1'b0;
      wdata_q <= '0;
      base_q  <= '0;
      addr_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          mode_q  <= mode_i;
          wr_q    <= wr_i;
          wdata_q <= wdata_i;
          base_q  <= base_sel;
          // prefix has no meaning for direct mode
          dbl_q   <= flag && (mode_i != MODE_W'(0));
          addr_q  <= (mode_i == MODE_W'(0)) ? base_sel : first_addr;
          st_q    <= (mode_i == MODE_W'(0)) ? ST_PTR : ST_ACC1;
        end
        ST_PTR: if (mem_ack_i) begin
          addr_q <= mem_rdata_i;
          st_q   <= ST_ACC1;
        end
        ST_ACC1: if (mem_ack_i) begin
          if (dbl_q) begin
            addr_q <= next_addr;
            st_q   <= ST_ACC2;
          end else begin
            st_q <= ST_DONE;
          end
        end
        ST_ACC2: if (mem_ack_i) st_q <= ST_DONE;
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (st_q == ST_PTR) || (st_q == ST_ACC1) || (st_q == ST_ACC2);
  assign mem_we_o   = wr_q && ((st_q == ST_ACC1) || (st_q == ST_ACC2));
  assign mem_addr_o = addr_q;

  always_comb begin
    if (!mem_we_o)            mem_wdata_o = '0;
    else if (st_q == ST_ACC2) mem_wdata_o = {{BW{1'b0}}, wdata_q[DW-1:BW]};
    else if (dbl_q)           mem_wdata_o = {{BW{1'b0}}, wdata_q[BW-1:0]};
    else                      mem_wdata_o = wdata_q;
  end

  assign done_o    = (st_q == ST_DONE);
  assign upd_en_o  = done_o && upd_en;
  assign upd_idx_o = (mode_q == MODE_W'(0)) ? PC_IDX : mode_q;

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o))); // R12
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(mem_ack_i && mem_req_o)); // R10
  AST_BYTE_WR_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && dbl_q) |-> (mem_wdata_o[DW-1:BW] == '0)); // R7
  AST_BUSY_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> $stable(mode_q)); // R11
endmodule

// File: tb/operand_seq_test.sv
`timescale 1ns/1ps
module operand_seq_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dbl_set = 1'b0, start = 1'b0, wr = 1'b0;
  logic [2:0]   mode = '0;
  logic [15:0]  wdata = '0;
  logic [127:0] ctrs = '0;
  logic         mem_req, mem_we, mem_ack = 1'b0, done, upd_en;
  logic [15:0]  mem_addr, mem_wdata, mem_rdata = '0, rdata, upd_val;
  logic [2:0]   upd_idx;

  always #2.5 clk = ~clk;

  operand_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .dbl_set_i(dbl_set), .start_i(start),
    .mode_i(mode), .wr_i(wr), .wdata_i(wdata), .ctrs_i(ctrs),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .done_o(done), .rdata_o(rdata), .upd_en_o(upd_en), .upd_idx_o(upd_idx),
    .upd_val_o(upd_val)
  );

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] mem [256];
  int          waits = 0, wcnt = 0, nacc = 0, last_ack = -10;
  logic [15:0] acc_addr [4];
  logic        acc_we   [4];
  logic [15:0] acc_wd   [4];
  logic        pend = 1'b0;
  logic [15:0] p_addr, p_wd;
  logic        p_we;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (pend) begin
        check("R12 addr", {16'h0, mem_addr}, {16'h0, p_addr});
        check("R12 we/wd", {15'h0, mem_we, mem_wdata}, {15'h0, p_we, p_wd});
      end
      if (wcnt >= waits) begin
        mem_ack = 1'b1;
        mem_rdata = mem[mem_addr[7:0]];
        if (nacc < 4) begin
          acc_addr[nacc] = mem_addr; acc_we[nacc] = mem_we; acc_wd[nacc] = mem_wdata;
        end
        nacc++;
        if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
        last_ack = cyc;
        wcnt = 0;
        pend = 1'b0;
      end else begin
        wcnt++;
        pend = 1'b1; p_addr = mem_addr; p_we = mem_we; p_wd = mem_wdata;
      end
    end else begin
      mem_ack = 1'b0;
      pend = 1'b0;
    end
  end

  function automatic logic [15:0] pat(input int a);
    logic [7:0] b = a[7:0];
    return {b ^ 8'hA5, b};
  endfunction

  task automatic init_mem;
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
  endtask

  task automatic set_ctr(input int k, input logic [15:0] v);
    ctrs[k*16 +: 16] = v;
  endtask

  // result of last op
  logic [15:0] r_rdata, r_val;
  logic        r_en;
  logic [2:0]  r_idx;

  task automatic pulse_dbl;
    @(negedge clk); dbl_set = 1'b1;
    @(negedge clk); dbl_set = 1'b0;
  endtask

  task automatic do_op(input string req, input logic [2:0] m, input logic w, input logic [15:0] d);
    int t;
    nacc = 0;
    @(negedge clk);
    mode = m; wr = w; wdata = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 60) begin
      @(negedge clk); t++;
    end
    check({req, " done"}, {31'h0, done}, 32'h1);
    check("R10 done timing", cyc, last_ack + 1);
    r_rdata = rdata; r_en = upd_en; r_idx = upd_idx; r_val = upd_val;
    @(negedge clk);
    check("R10 pulse", {31'h0, done}, 32'h0);
  endtask

  task automatic t_reset;
    check("R1 req", {31'h0, mem_req}, 32'h0);
    check("R1 done", {31'h0, done}, 32'h0);
    check("R1 upd", {31'h0, upd_en}, 32'h0);
  endtask

  task automatic t_direct;
    init_mem(); waits = 0;
    set_ctr(7, 16'h0020); mem[8'h20] = 16'h0033;
    do_op("R2", 3'd0, 1'b0, 16'h0);
    check("R2 nacc", nacc, 2);
    check("R2 ptr addr", {16'h0, acc_addr[0]}, 32'h0020);
    check("R2 op addr", {16'h0, acc_addr[1]}, 32'h0033);
    check("R2 rdata", {16'h0, r_rdata}, {16'h0, pat(8'h33)});
    check("R2 upd", {12'h0, r_en, r_idx, r_val}, {12'h0, 1'b1, 3'd7, 16'h0021});
    // prefix ignored in direct mode, then cleared
    pulse_dbl();
    do_op("R2", 3'd0, 1'b1, 16'hBEEF);
    check("R2 dbl nacc", nacc, 2);
    check("R2 dbl write", {16'h0, mem[8'h33]}, 32'hBEEF);
    set_ctr(1, 16'h0050);
    do_op("R9", 3'd1, 1'b0, 16'h0);
    check("R9 flag cleared by direct", nacc, 1);
  endtask

  task automatic t_plain;
    init_mem(); waits = 0;
    for (int k = 1; k <= 3; k++) begin
      set_ctr(k, 16'(16'h0010 * k));
      do_op("R3", 3'(k), 1'b0, 16'h0);
      check("R3 addr", {16'h0, acc_addr[0]}, 32'(16'h0010 * k));
      check("R8 rdata", {16'h0, r_rdata}, {16'h0, pat(16 * k)});
      check("R3 no upd", {31'h0, r_en}, 32'h0);
    end
  endtask

  task automatic t_incr;
    init_mem(); waits = 1;
    set_ctr(4, 16'h0044); set_ctr(5, 16'h0055);
    do_op("R4", 3'd4, 1'b0, 16'h0);
    check("R4 addr", {16'h0, acc_addr[0]}, 32'h0044);
    check("R4 upd", {12'h0, r_en, r_idx, r_val}, {12'h0, 1'b1, 3'd4, 16'h0045});
    do_op("R4", 3'd5, 1'b1, 16'h1234);
    check("R4 wr", {16'h0, mem[8'h55]}, 32'h1234);
    check("R4 upd5", {12'h0, r_en, r_idx, r_val}, {12'h0, 1'b1, 3'd5, 16'h0056});
    waits = 0;
  endtask

  task automatic t_stack;
    init_mem(); waits = 0;
    set_ctr(6, 16'h0040);
    do_op("R5", 3'd6, 1'b1, 16'hCAFE);
    check("R5 push addr", {16'h0, acc_addr[0]}, 32'h0040);
    check("R5 push upd", {16'h0, r_val}, 32'h0041);
    do_op("R5", 3'd6, 1'b0, 16'h0);
    check("R5 pop addr", {16'h0, acc_addr[0]}, 32'h003F);
    check("R5 pop upd", {12'h0, r_en, r_idx, r_val}, {12'h0, 1'b1, 3'd6, 16'h003F});
  endtask

  task automatic t_imm;
    init_mem(); waits = 2;
    set_ctr(7, 16'h0070);
    do_op("R6", 3'd7, 1'b0, 16'h0);
    check("R6 addr", {16'h0, acc_addr[0]}, 32'h0070);
    check("R6 rdata", {16'h0, r_rdata}, {16'h0, pat(8'h70)});
    check("R6 upd", {12'h0, r_en, r_idx, r_val}, {12'h0, 1'b1, 3'd7, 16'h0071});
    waits = 0;
  endtask

  task automatic t_dbl;
    init_mem(); waits = 0;
    set_ctr(2, 16'h0022);
    pulse_dbl();
    do_op("R7", 3'd2, 1'b0, 16'h0);
    check("R7 same addr", {acc_addr[0], acc_addr[1]}, 32'h00220022);
    check("R7 rdata", {16'h0, r_rdata}, 32'h2222);
    check("R7 no upd", {31'h0, r_en}, 32'h0);
    do_op("R9", 3'd2, 1'b0, 16'h0);
    check("R9 one-shot", nacc, 1);
    set_ctr(4, 16'h0080);
    pulse_dbl();
    do_op("R7", 3'd4, 1'b0, 16'h0);
    check("R7 inc addr", {acc_addr[0], acc_addr[1]}, 32'h00800081);
    check("R7 rdata inc", {16'h0, r_rdata}, 32'h8180);
    check("R7 upd +2", {16'h0, r_val}, 32'h0082);
    set_ctr(7, 16'h0090);
    pulse_dbl();
    do_op("R7", 3'd7, 1'b1, 16'hA1B2);
    check("R7 wr lo", {16'h0, acc_wd[0]}, 32'h00B2);
    check("R7 wr hi", {16'h0, acc_wd[1]}, 32'h00A1);
    check("R7 wr addr", {acc_addr[0], acc_addr[1]}, 32'h00900091);
    check("R7 imm upd", {16'h0, r_val}, 32'h0092);
    set_ctr(6, 16'h0060);
    pulse_dbl();
    do_op("R7", 3'd6, 1'b0, 16'h0);
    check("R7 pop addr", {acc_addr[0], acc_addr[1]}, 32'h005F005E);
    check("R7 pop data", {16'h0, r_rdata}, 32'h5E5F);
    check("R7 pop upd", {16'h0, r_val}, 32'h005E);
    pulse_dbl();
    do_op("R7", 3'd6, 1'b1, 16'h7788);
    check("R7 push addr", {acc_addr[0], acc_addr[1]}, 32'h00600061);
    check("R7 push upd", {16'h0, r_val}, 32'h0062);
  endtask

  task automatic t_busy;
    int t;
    init_mem(); waits = 3; nacc = 0;
    set_ctr(4, 16'h00A0); set_ctr(1, 16'h0011);
    @(negedge clk); mode = 3'd4; wr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); mode = 3'd1; wr = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!done && t < 60) begin @(negedge clk); t++; end
    check("R11 idx", {29'h0, upd_idx}, 32'h4);
    repeat (4) @(negedge clk);
    check("R11 nacc", nacc, 1);
    check("R11 addr", {16'h0, acc_addr[0]}, 32'h00A0);
    check("R11 idle", {31'h0, mem_req}, 32'h0);
    check("R11 mem", {16'h0, mem[8'h11]}, {16'h0, pat(8'h11)});
    waits = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    init_mem();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_direct();
    t_plain();
    t_incr();
    t_stack();
    t_imm();
    t_dbl();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule